// File: doc/BRIEF.md
# Programmable Sample-Rate Pulse Generator

This block produces the sampling strobe for an acquisition system from a single fast clock and a slow base enable. A 100 kHz base enable (`base_tick`, one clock wide) drives a chain of five divide-by-ten stages. Each stage is a clock enable in the one clock domain, not a derived clock, so six rates are available: the base rate and the output of each stage. One of them is chosen, and a 4-bit variable-modulus counter divides the chosen rate by any integer from 1 to 16.

The output is given in two forms. `out_tick` is a one-clock strobe marking the start of each output pulse. `out_level` is a level that stays high for exactly one period of the chosen rate, from the tick that starts the pulse up to the next chosen tick. A start/stop latch gates the divider, so bouncing start or stop inputs cannot insert counts. A new divide setting or a new rate choice is taken up only when the counter wraps, so the output never carries a shortened pulse.

Top module: `samp_clk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `running`, `out_tick` and `out_level` are low.
- R2: The prescaler counts base ticks from reset. Rate choice 0 is the base tick itself, and rate choice k (1 to 5) ticks on the base tick that makes the count since reset a multiple of 10^k. The prescaler runs whether or not the divider is running.
- R3: A rate choice above 5 (the field is 3 bits wide) selects stage 5.
- R4: With a divide setting N from 2 to 15, `out_tick` pulses for one clock once every N chosen ticks. The first pulse follows the Nth chosen tick after start, and each pulse comes one clock after the chosen tick that caused it.
- R5: A divide setting of 0 divides by 16.
- R6: A divide setting of 1 bypasses the counter. Every chosen tick produces `out_tick`, and `out_level` then stays high while the divider runs.
- R7: `out_level` rises together with `out_tick` and falls one clock after the next chosen tick that does not start a new pulse.
- R8: `start_req` sets `running` on the next clock, and `stop_req` clears it; when both are high, stop wins. A start while the divider is already running does not disturb the count. While stopped, no `out_tick` appears, `out_level` is low and the count restarts from zero on the next start.
- R9: A change of the divide setting or of the rate choice while running takes effect only at the next counter wrap. While stopped, changes take effect at once.
- R10: While `base_tick` is low, neither the prescaler nor the divider advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-clock base-rate enable (100 kHz) |
| rate_sel | input | 3 | Rate choice: 0 base, 1..5 stage output, above 5 clamps to 5 |
| div_set | input | 4 | Divide setting: 1..15 divide by N, 0 divide by 16 |
| start_req | input | 1 | Sets the run latch |
| stop_req | input | 1 | Clears the run latch, dominant |
| running | output | 1 | Run latch state |
| out_tick | output | 1 | One-clock strobe at the start of each output pulse |
| out_level | output | 1 | Output pulse, one chosen-rate period long |

## Verification
The assertions assume that `base_tick` is a synchronous enable that may sit high for many clocks, and that `start_req`, `stop_req`, `rate_sel` and `div_set` change only between clock edges. They allow these inputs to change in any cycle, including the cycle of a wrap. The stimulus drives every input on the falling clock edge. It keeps `base_tick` either continuously high or pulsed on a fixed spacing. It changes the setting and the rate choice both mid-count and while stopped. The stop-dominance case drives start and stop together, and the clamp case uses the out-of-range rate code 7.

// File: rtl/samp_clk_pkg.sv
package samp_clk_pkg;

   // Saturating clamp used for the rate-choice decode.
   function automatic int unsigned clamp_u(input int unsigned v, input int unsigned hi);
      return (v > hi) ? hi : v;
   endfunction

   // Terminal count for a modulus setting: the setting minus one, wrapping
   // so that a zero setting gives the largest modulus.
   function automatic int unsigned term_count(input int unsigned setting, input int unsigned width);
      int unsigned m;
      m = 1 << width;
      return (setting + m - 1) % m;
   endfunction

endpackage

// File: rtl/samp_clk_prescale.sv
module samp_clk_prescale #(
   parameter int NUM_STAGES = 5,
   parameter int RADIX      = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  base_tick,
   output logic [NUM_STAGES:0]   ticks
);
   localparam int CW = (RADIX > 2) ? $clog2(RADIX) : 1;
   localparam logic [CW-1:0] LAST = CW'(RADIX - 1);
   localparam bit POW2 = ((RADIX & (RADIX - 1)) == 0);

   logic [CW-1:0] cnt [NUM_STAGES];

   // Enable chain: stage s fires on its input tick when its count is terminal.
   always_comb begin
      ticks[0] = base_tick;
      for (int s = 0; s < NUM_STAGES; s++) begin
         ticks[s+1] = ticks[s] && (cnt[s] == LAST);
      end
   end

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (POW2) begin : g_natural
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt[s] <= '0;
            else if (ticks[s]) cnt[s] <= cnt[s] + 1'b1;
         end
      end else begin : g_compare
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt[s] <= '0;
            else if (ticks[s]) cnt[s] <= (cnt[s] == LAST) ? '0 : cnt[s] + 1'b1;
         end
      end

      // R2
      stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt[s] <= LAST);
      // R10
      stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !base_tick |=> $stable(cnt[s]));
   end

endmodule

// File: rtl/samp_clk_tick_sel.sv
module samp_clk_tick_sel #(
   parameter int NUM_STAGES = 5,
   parameter int SEL_W      = 3
) (
   input  logic [NUM_STAGES:0] ticks,
   input  logic [SEL_W-1:0]    sel,
   output logic                sel_tick
);
   always_comb begin
      sel_tick = 1'b0;
      for (int i = 0; i <= NUM_STAGES; i++) begin
         if (sel == SEL_W'(i)) sel_tick = ticks[i];
      end
   end
endmodule

// File: rtl/samp_clk_run_latch.sv
module samp_clk_run_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   output logic running
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         running <= 1'b0;
      else if (stop_req)  running <= 1'b0;
      else if (start_req) running <= 1'b1;
   end

   // R8
   stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !running);
   // R8
   start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && !stop_req |=> running);
endmodule

// File: rtl/samp_clk_divider.sv
module samp_clk_divider
   import samp_clk_pkg::*;
#(
   parameter int NUM_STAGES = 5,
   parameter int SEL_W      = 3,
   parameter int MOD_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sel_tick,
   input  logic [MOD_W-1:0] div_set,
   input  logic [SEL_W-1:0] rate_req,
   output logic [SEL_W-1:0] act_sel,
   output logic             out_tick,
   output logic             out_level
);
   logic [MOD_W-1:0] cnt;
   logic [MOD_W-1:0] act_lim;
   logic [MOD_W-1:0] next_lim;
   logic [SEL_W-1:0] next_sel;
   logic             bypass;
   logic             wrap;

   assign next_lim = MOD_W'(term_count(int'(div_set), MOD_W));
   assign next_sel = SEL_W'(clamp_u(int'(rate_req), NUM_STAGES));
   assign bypass   = (act_lim == '0);
   assign wrap     = run && sel_tick && (bypass || (cnt == act_lim));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_lim   <= '0;
         act_sel   <= '0;
         out_tick  <= 1'b0;
         out_level <= 1'b0;
      end else if (!run) begin
         cnt       <= '0;
         act_lim   <= next_lim;
         act_sel   <= next_sel;
         out_tick  <= 1'b0;
         out_level <= 1'b0;
      end else begin
         out_tick <= wrap;
         if (wrap) begin
            cnt       <= '0;
            act_lim   <= next_lim;
            act_sel   <= next_sel;
            out_level <= 1'b1;
         end else if (sel_tick) begin
            cnt       <= cnt + 1'b1;
            out_level <= 1'b0;
         end
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act_lim);
   // R7
   level_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> out_level);
   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !sel_tick |=> $stable(out_level));
   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !wrap |=> $stable(act_lim) && $stable(act_sel));
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !out_tick && !out_level && (cnt == '0));
   // R6
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && sel_tick && (act_lim == '0) |=> out_tick);
endmodule

// File: rtl/samp_clk_gen.sv
module samp_clk_gen #(
   parameter int NUM_STAGES = 5,
   parameter int RADIX      = 10,
   parameter int MOD_W      = 4,
   parameter int SEL_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_tick,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic [MOD_W-1:0] div_set,
   input  logic             start_req,
   input  logic             stop_req,
   output logic             running,
   output logic             out_tick,
   output logic             out_level
);
   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("samp_clk_gen: NUM_STAGES must be at least 1");
   end
   if (RADIX < 2) begin : g_bad_radix
      $error("samp_clk_gen: RADIX must be at least 2");
   end
   if (MOD_W < 1 || MOD_W > 16) begin : g_bad_mod
      $error("samp_clk_gen: MOD_W out of range");
   end
   if ((1 << SEL_W) < NUM_STAGES + 1) begin : g_bad_sel
      $error("samp_clk_gen: SEL_W too narrow for NUM_STAGES");
   end

   logic [NUM_STAGES:0] ticks;
   logic [SEL_W-1:0]    act_sel;
   logic                sel_tick;

   samp_clk_prescale #(.NUM_STAGES(NUM_STAGES), .RADIX(RADIX)) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .ticks     (ticks)
   );

   samp_clk_tick_sel #(.NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)) u_sel (
      .ticks    (ticks),
      .sel      (act_sel),
      .sel_tick (sel_tick)
   );

   samp_clk_run_latch u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .stop_req  (stop_req),
      .running   (running)
   );

   samp_clk_divider #(.NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W), .MOD_W(MOD_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (running),
      .sel_tick  (sel_tick),
      .div_set   (div_set),
      .rate_req  (rate_sel),
      .act_sel   (act_sel),
      .out_tick  (out_tick),
      .out_level (out_level)
   );

   // R10
   sel_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_tick |-> base_tick);
   // R3
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_sel <= SEL_W'(NUM_STAGES));
endmodule

// File: tb/samp_clk_gen_tb.sv
module samp_clk_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic [2:0] rate_sel = 3'd0;
   logic [3:0] div_set = 4'd3;
   logic       start_req = 1'b0;
   logic       stop_req = 1'b0;
   logic       running, out_tick, out_level;

   always #4 clk = ~clk;

   samp_clk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
      .div_set(div_set), .start_req(start_req), .stop_req(stop_req),
      .running(running), .out_tick(out_tick), .out_level(out_level)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string tag = "R1";
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: base ticks since reset, chosen ticks since last pulse.
   longint bc;
   int     m_seen, m_div, m_rate;
   bit     m_run, m_tick, m_lvl;

   function automatic longint p10(input int k);
      longint r = 1;
      for (int i = 0; i < k; i++) r = r * 10;
      return r;
   endfunction

   always @(posedge clk) begin : ref_model
      bit st;
      bit tn;
      if (!rst_n) begin
         bc = 0; m_seen = 0; m_div = 3; m_rate = 0;
         m_run = 0; m_tick = 0; m_lvl = 0;
      end else begin
         st = 1'b0;
         tn = 1'b0;
         if (base_tick) begin
            bc = bc + 1;
            st = ((bc % p10(m_rate)) == 0);
         end
         if (!m_run) begin
            m_seen = 0;
            m_lvl  = 1'b0;
            m_div  = (div_set == 0) ? 16 : int'(div_set);
            m_rate = (rate_sel > 5) ? 5 : int'(rate_sel);
         end else if (st) begin
            m_seen = m_seen + 1;
            if (m_seen == m_div) begin
               m_seen = 0;
               tn     = 1'b1;
               m_lvl  = 1'b1;
               m_div  = (div_set == 0) ? 16 : int'(div_set);
               m_rate = (rate_sel > 5) ? 5 : int'(rate_sel);
            end else begin
               m_lvl = 1'b0;
            end
         end
         m_tick = tn;
         if (stop_req)       m_run = 1'b0;
         else if (start_req) m_run = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(running === m_run, "running", running, m_run);
         chk(out_tick === m_tick, "out_tick", out_tick, m_tick);
         chk(out_level === m_lvl, "out_level", out_level, m_lvl);
      end
   end

   task automatic do_start();
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic count_win(input int w, output int np, output int nl);
      np = 0; nl = 0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         if (out_tick)  np++;
         if (out_level) nl++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      int np, nl;
      // R1: reset state
      repeat (3) @(negedge clk);
      tag = "R1";
      chk(running === 1'b0, "running in reset", running, 0);
      chk(out_tick === 1'b0, "out_tick in reset", out_tick, 0);
      chk(out_level === 1'b0, "out_level in reset", out_level, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      chk(running === 1'b0, "running after reset", running, 0);
      base_tick = 1'b1;

      // R4: divide by 3 at the base rate
      tag = "R4"; rate_sel = 3'd0; div_set = 4'd3;
      do_start(); count_win(30, np, nl);
      chk(np == 10, "R4 pulses div3 in 30", np, 10);
      do_stop();

      // R4: divide by 7
      div_set = 4'd7;
      do_start(); count_win(70, np, nl);
      chk(np == 10, "R4 pulses div7 in 70", np, 10);
      do_stop();

      // R5: setting 0 divides by 16
      tag = "R5"; div_set = 4'd0;
      do_start(); count_win(64, np, nl);
      chk(np == 4, "R5 pulses div16 in 64", np, 4);
      do_stop();

      // R6: setting 1 bypasses, level stays high
      tag = "R6"; div_set = 4'd1;
      do_start(); count_win(20, np, nl);
      chk(np == 20, "R6 pulses div1 in 20", np, 20);
      chk(nl == 20, "R6 level-high cycles", nl, 20);
      do_stop();

      // R7: sparse base ticks, level spans one chosen period
      tag = "R7"; div_set = 4'd4;
      do_start();
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); base_tick = 1'b1;
         @(negedge clk); base_tick = 1'b0;
         @(negedge clk);
      end
      base_tick = 1'b1;
      do_stop();

      // R2: stage outputs
      tag = "R2"; rate_sel = 3'd1; div_set = 4'd2;
      do_start(); count_win(200, np, nl);
      chk(np == 10, "R2 stage1 div2 in 200", np, 10);
      do_stop();
      rate_sel = 3'd2; div_set = 4'd1;
      do_start(); count_win(500, np, nl);
      chk(np == 5, "R2 stage2 div1 in 500", np, 5);
      do_stop();

      // R9: setting change mid-count waits for the wrap
      tag = "R9"; rate_sel = 3'd0; div_set = 4'd8;
      do_start();
      div_set = 4'd2;
      count_win(8, np, nl);
      chk(np == 1, "R9 old divisor kept to wrap", np, 1);
      count_win(10, np, nl);
      chk(np == 5, "R9 new divisor after wrap", np, 5);
      rate_sel = 3'd1;
      count_win(2, np, nl);
      count_win(60, np, nl);
      chk(np == 3, "R9 new rate after wrap", np, 3);
      do_stop();
      rate_sel = 3'd0;

      // R8: stop dominance, restart while running, quiet when stopped
      tag = "R8"; div_set = 4'd5;
      do_start(); count_win(3, np, nl);
      do_start(); count_win(10, np, nl);
      chk(np == 2, "R8 restart keeps count", np, 2);
      @(negedge clk); start_req = 1'b1; stop_req = 1'b1;
      @(negedge clk); start_req = 1'b0; stop_req = 1'b0;
      chk(running === 1'b0, "R8 stop wins", running, 0);
      count_win(20, np, nl);
      chk(np == 0, "R8 no pulses while stopped", np, 0);
      chk(nl == 0, "R8 level low while stopped", nl, 0);

      // R10: base tick low freezes everything
      tag = "R10"; div_set = 4'd3;
      do_start(); count_win(2, np, nl);
      base_tick = 1'b0;
      count_win(25, np, nl);
      chk(np == 0, "R10 no pulses without base", np, 0);
      base_tick = 1'b1;
      count_win(1, np, nl);
      chk(np == 1, "R10 resumes at third tick", np, 1);
      do_stop();

      // R3: out-of-range rate code clamps to stage 5
      tag = "R3"; rate_sel = 3'd7; div_set = 4'd1;
      do_start();
      np = 0;
      while (bc < 100005) begin
         @(negedge clk);
         if (out_tick) np++;
      end
      chk(np == 1, "R3 stage5 pulses to 100005", np, 1);
      do_stop();

      finish_run();
   end
endmodule